// File: doc/BRIEF.md
# Elastic Valid-Ready Buffer Chain

This block is a parameterised chain of single-entry elastic buffers. Each stage sits between a producer and a consumer that use a valid/ready handshake. Each stage holds one data word and one occupancy bit. No central controller sequences the stages. Each stage decides on its own, from its local handshake, whether it takes in a word and whether it hands one on. A word therefore moves forward whenever the next stage can take it, and does not wait for the slowest stage in the chain.

Each stage handles a transfer in and a transfer out in the same cycle explicitly. In that cycle the stage keeps its occupancy bit set and loads the incoming word over the word that is leaving. If this case were left unreachable, a stage would only pass a word every other cycle. With the case handled, a producer that always offers data and a consumer that always accepts it see one word per clock across the whole chain. A stage also reports ready while it is full, provided its consumer is ready, so a draining stage can refill in the same cycle.

Top module: `elastic_pipe`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid_o is 0 and in_ready_o is 1.
- R2: A word is taken from the producer only on a rising clock edge where in_valid_i and in_ready_o are both 1. A word is delivered only on a rising edge where out_valid_o and out_ready_i are both 1.
- R3: Every word that is taken is delivered exactly once, with its value unchanged and in the order it was taken.
- R4: in_ready_o is 1 whenever out_ready_i is 1, in the same cycle, whatever the chain holds.
- R5: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o keeps its value on the next cycle.
- R6: If in_valid_i and out_ready_i are both held at 1, then after the first word arrives the chain delivers one word on every clock, with no gap.
- R7: Suppose a word is taken at a clock edge while the chain is empty and out_ready_i is 1. That word is presented on out_valid_o/out_data_o after STAGES rising edges, counted from and including the edge that took it.
- R8: With out_ready_i held at 0, the chain takes exactly STAGES words and then holds in_ready_o at 0.
- R9: When no word is taken, the value on in_data_i has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Producer offers a word |
| in_data_i | input | DATA_W | Word offered by producer |
| in_ready_o | output | 1 | Chain can take a word this cycle |
| out_valid_o | output | 1 | Chain presents a word |
| out_data_o | output | DATA_W | Word presented to consumer |
| out_ready_i | input | 1 | Consumer takes the presented word |

## Verification
in_ready_o depends combinationally on out_ready_i and on the stage occupancy, so it is due in the same cycle as the inputs. The bench therefore drives inputs on the falling edge and samples in_ready_o a quarter period later. out_valid_o and out_data_o change only at rising edges, and a word taken into an empty chain appears STAGES edges later. A behavioural slot model in the bench is advanced once per rising edge and compared against the outputs before the next edge, so every cycle is checked at the point where its value is due. A queue scoreboard confirms order and loss-free delivery, and dedicated phases count accepted words under a stall and delivered words under full streaming.

// File: rtl/elastic_pkg.sv
package elastic_pkg;
  // {write, read} event of one stage
  typedef enum logic [1:0] {
    EV_IDLE  = 2'b00,
    EV_READ  = 2'b01,
    EV_WRITE = 2'b10,
    EV_BOTH  = 2'b11
  } xfer_ev_e;

  function automatic xfer_ev_e classify(input logic wr, input logic rd);
    return xfer_ev_e'({wr, rd});
  endfunction
endpackage

// File: rtl/occ_flag.sv
module occ_flag
  import elastic_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  xfer_ev_e ev_i,
  output logic     full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_o <= 1'b0;
    else begin
      unique case (ev_i)
        EV_READ:  full_o <= 1'b0;
        EV_WRITE: full_o <= 1'b1;
        EV_BOTH:  full_o <= 1'b1; // swap: leaves and refills together
        default:  full_o <= full_o;
      endcase
    end
  end
endmodule

// File: rtl/data_hold.sv
module data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/elastic_stage.sv
module elastic_stage
  import elastic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  output logic              up_ready_o,
  output logic              dn_valid_o,
  output logic [DATA_W-1:0] dn_data_o,
  input  logic              dn_ready_i
);
  logic     full, wr, rd;
  xfer_ev_e ev;

  // ready while empty, or while the held word leaves this cycle
  assign up_ready_o = !full || dn_ready_i;
  assign wr         = up_valid_i && up_ready_o;
  assign rd         = full && dn_ready_i;
  assign ev         = classify(wr, rd);
  assign dn_valid_o = full;

  occ_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .full_o (full)
  );

  data_hold #(.DATA_W(DATA_W)) u_data (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr),
    .d_i    (up_data_i),
    .q_o    (dn_data_o)
  );
endmodule

// File: rtl/elastic_pipe.sv
module elastic_pipe #(
  parameter int DATA_W = 8,
  parameter int STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  localparam int LINKS = STAGES + 1;

  logic [LINKS-1:0]             lv;
  logic [LINKS-1:0]             lr;
  logic [LINKS-1:0][DATA_W-1:0] ld;

  assign lv[0]       = in_valid_i;
  assign ld[0]       = in_data_i;
  assign in_ready_o  = lr[0];
  assign out_valid_o = lv[STAGES];
  assign out_data_o  = ld[STAGES];
  assign lr[STAGES]  = out_ready_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    elastic_stage #(.DATA_W(DATA_W)) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .up_valid_i (lv[g]),
      .up_data_i  (ld[g]),
      .up_ready_o (lr[g]),
      .dn_valid_o (lv[g+1]),
      .dn_data_o  (ld[g+1]),
      .dn_ready_i (lr[g+1])
    );
  end
endmodule

// File: rtl/elastic_pipe_chk.sv
module elastic_pipe_chk #(
  parameter int DATA_W = 8,
  parameter int STAGES = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ready_i
);
  localparam int CW = $clog2(STAGES + 1) + 1;
  localparam logic [CW-1:0] CAP = CW'(STAGES);

  logic [CW-1:0] cnt;
  logic acc, del;
  assign acc = in_valid_i && in_ready_o;
  assign del = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else         cnt <= cnt + CW'(acc) - CW'(del);
  end

  // R1: reset empties the chain
  always @(posedge clk_i) if (!rst_ni)
    a_r1_reset_empty: assert (!out_valid_o && in_ready_o);

  a_r4_ready_when_draining: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |-> in_ready_o);

  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CAP);

  a_r8_full_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CAP && !out_ready_i) |-> !in_ready_o);

  a_r3_no_phantom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> cnt != '0);

  logic unused_data;
  assign unused_data = ^in_data_i;
endmodule

bind elastic_pipe elastic_pipe_chk #(.DATA_W(DATA_W), .STAGES(STAGES)) u_chk (.*);

// File: tb/elastic_pipe_bench.sv
module elastic_pipe_bench;
  localparam int DATA_W = 8;
  localparam int STAGES = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              in_ready_o;
  logic              out_valid_o;
  logic [DATA_W-1:0] out_data_o;
  logic              out_ready_i = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  elastic_pipe #(.DATA_W(DATA_W), .STAGES(STAGES)) u_elastic_pipe (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i)
  );

  // behavioural slot model
  bit m_full[STAGES];
  int m_data[STAGES];
  int sb[$];
  int n_acc, n_del;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, check before rising edge, advance model
  task automatic step(input bit v, input int d, input bit r);
    bit rdy[STAGES+1];
    bit nf[STAGES];
    int nd[STAGES];
    in_valid_i = v; in_data_i = DATA_W'(d); out_ready_i = r;
    #5;
    rdy[STAGES] = r;
    for (int i = STAGES-1; i >= 0; i--) rdy[i] = !m_full[i] || rdy[i+1];
    chk("R4 in_ready", int'(in_ready_o), int'(rdy[0]));
    chk("R7 out_valid", int'(out_valid_o), int'(m_full[STAGES-1]));
    if (m_full[STAGES-1]) chk("R9 out_data", int'(out_data_o), m_data[STAGES-1]);
    if (v && rdy[0]) begin sb.push_back(d & 255); n_acc++; end
    if (out_valid_o && r) begin
      n_del++;
      if (sb.size() == 0) chk("R3 phantom word", 1, 0);
      else chk("R3 order", int'(out_data_o), sb.pop_front());
    end
    for (int i = 0; i < STAGES; i++) begin
      bit up_v = (i == 0) ? v : m_full[i-1];
      int up_d = (i == 0) ? (d & 255) : m_data[i-1];
      bit rd = m_full[i] && rdy[i+1];
      bit wr = up_v && rdy[i];
      nf[i] = wr ? 1'b1 : (rd ? 1'b0 : m_full[i]);
      nd[i] = wr ? up_d : m_data[i];
    end
    @(posedge clk);
    m_full = nf; m_data = nd;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < STAGES; i++) begin m_full[i] = 0; m_data[i] = 0; end
    #25;
    chk("R1 out_valid in reset", int'(out_valid_o), 0);
    chk("R1 in_ready in reset", int'(in_ready_o), 1);
    @(negedge clk); rst_ni = 1'b1;
    #5;
    chk("R1 out_valid after reset", int'(out_valid_o), 0);
    @(negedge clk);

    // R7: latency into an empty chain
    step(1, 8'h5a, 1);
    for (int k = 1; k < STAGES; k++) begin
      chk("R7 not early", int'(out_valid_o), 0);
      step(0, 8'hff, 1);
    end
    chk("R7 arrives", int'(out_valid_o), 1);
    chk("R7 data", int'(out_data_o), 8'h5a);
    step(0, 0, 1);

    // R8 and R5: stall with producer pushing
    n_acc = 0;
    for (int k = 0; k < 10; k++) step(1, 16 + k, 0);
    chk("R8 accepted under stall", n_acc, STAGES);
    chk("R5 held word", int'(out_data_o), 16);
    // R9: idle data noise then drain
    for (int k = 0; k < 6; k++) step(0, 200 + k, 1);
    chk("R3 drained", sb.size(), 0);

    // R6: streaming
    n_del = 0;
    for (int k = 0; k < STAGES; k++) step(1, 40 + k, 1);
    n_del = 0;
    for (int k = 0; k < 40; k++) step(1, 60 + k, 1);
    chk("R6 one per clock", n_del, 40);

    // R2/R3: random handshakes
    for (int k = 0; k < 3000; k++) step(($urandom % 3) != 0, $urandom % 256, ($urandom % 2) == 1);
    for (int k = 0; k < 2 * STAGES; k++) step(0, 0, 1);
    chk("R3 lossless", sb.size(), 0);
    chk("R2 chain empty", int'(out_valid_o), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) chk("watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule